// File: doc/BRIEF.md
# I2C Target Byte Engine with Selectable Clock Stretching

This block is the target side of an I2C bus. It takes the raw SCL and SDA levels, passes them through a synchronizer, and recognises START and STOP. It compares the first byte with a 7-bit own address. After a match it either shifts received bytes into a single buffer register or shifts bytes out of that same register. It drives the bus only through two open-drain pull-low enables.

Software sees a small register-style interface. One bit enables stretching and another chooses where the stretch happens: after the 8th or after the 9th SCL falling edge of every byte. Software also writes the acknowledge value and reads or writes the buffer. While the block pulls SCL low, a hold flag is raised. Software clears that flag once the buffer has been serviced. When the stretch point is the 8th edge, software can still change the acknowledge value while the hold lasts, and the new value goes onto SDA at once.

The controller has these states: `ST_IDLE`, `ST_ADDR` (address bits), `ST_AACK` (address acknowledge), `ST_RX`/`ST_RACK` (receive byte and its acknowledge), `ST_TX`/`ST_HACK` (transmit byte and host acknowledge), `ST_HOLD8`/`ST_HOLD9` (stretching) and `ST_SKIP` (ignore until the next START). The transitions are as follows:
- START from any state leads to `ST_ADDR`. STOP from any state leads to `ST_IDLE`.
- On the 8th fall, `ST_ADDR` goes to `ST_AACK` on a match or to `ST_SKIP` on a mismatch. `ST_RX` goes to `ST_RACK`, and `ST_TX` goes to `ST_HACK`. Each of these three goes instead to `ST_HOLD8` when stretching at the 8th edge is selected.
- On the 9th fall, an acknowledge state goes to `ST_TX` or `ST_RX`, or to `ST_HOLD9` when stretching at the 9th edge is selected. A host NACK in `ST_HACK` leads to `ST_SKIP`.
- A clear of the hold flag leaves `ST_HOLD8` for the pending acknowledge state, and leaves `ST_HOLD9` for `ST_TX` or `ST_RX`.

Top module: `i2c_tgt_stretch`

## Requirements
- R1: After reset both pull enables are 0, and `hold_flag`, `busy` and `ovr_flag` are 0.
- R2: An address byte is taken MSB first. Bits 7..1 are compared with `own_addr` and bit 0 is the direction (1 = host reads). On a match the block pulls SDA low during the 9th clock, whatever the value of `ack_val`.
- R3: A received data byte is shifted in MSB first and stored in `buf_rdata` at the 8th SCL fall. During the 9th clock SDA is pulled low when `ack_val` = 0 and left released when `ack_val` = 1.
- R4: A non-matching address gets no acknowledge, and neither does any later byte up to the next START. The buffer is not changed and SCL is never held.
- R5: With `str_en` = 1, SCL is held low after the 9th SCL fall of every byte when `str_at8` = 0, and after the 8th fall when `str_at8` = 1. With `str_en` = 0, SCL is never held.
- R6: `hold_flag` is 1 exactly while SCL is held. The hold lasts until `hold_clr` is pulsed, and SCL is released on the next clock after that pulse.
- R7: During a hold at the 8th fall of a received byte, SDA follows the current `ack_val`. A change made by software before the release appears on SDA within one clock.
- R8: A byte that completes while the previous received byte is still unread sets `ovr_flag` and is discarded. `buf_rd` marks the buffer as read, and `ovr_clr` clears the flag.
- R9: `busy` is 1 during the address bits, the bits of a received byte, and the bits and host acknowledge of a transmitted byte. It drops at the 8th fall of an address or received byte and at the 9th fall of a transmitted byte, so it is 0 during every hold.
- R10: In a read, the buffer is shifted out MSB first. A host ACK requests the next byte. A host NACK ends the read: SDA is released and no stretch happens until STOP or START.
- R11: The block changes its SDA pull only while the synchronized SCL is low.
- R12: START sets `busy` and restarts address reception. STOP returns the block to idle with `busy` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL bus level |
| sda_i | input | 1 | SDA bus level |
| scl_pull | output | 1 | 1 pulls SCL low |
| sda_pull | output | 1 | 1 pulls SDA low |
| own_addr | input | 7 | Address this target answers to |
| str_en | input | 1 | Clock stretch enable |
| str_at8 | input | 1 | Stretch point: 1 = 8th fall, 0 = 9th fall |
| ack_val | input | 1 | Acknowledge bit for received data (0 = ACK) |
| buf_wr | input | 1 | Write strobe for the buffer |
| buf_wdata | input | 8 | Byte to transmit |
| buf_rd | input | 1 | Marks the received byte as read |
| buf_rdata | output | 8 | Buffer contents |
| hold_flag | output | 1 | SCL is being held low |
| hold_clr | input | 1 | Clears the hold flag and releases SCL |
| busy | output | 1 | A byte is in progress |
| ovr_flag | output | 1 | Receive overrun has happened |
| ovr_clr | input | 1 | Clears the overrun flag |

## Verification
If the state register ends up in the wrong acknowledge or hold state, the bus shows it within one SCL period: an acknowledge bit sampled by the host has the wrong polarity, or SCL is held at the 8th fall when the 9th was selected. A bit counter that is off by one either moves the hold point or produces an SDA change while SCL is high, and a per-clock bus-rule monitor catches that on the same system cycle. Damage to the buffer or overrun bookkeeping appears as the wrong byte read back by software during a hold, or in a read transfer.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_RX,
        ST_RACK,
        ST_TX,
        ST_HACK,
        ST_HOLD8,
        ST_HOLD9,
        ST_SKIP
    } tgt_state_t;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic [LINES-1:0] prev;

    assign raw = {sda_i, scl_i};

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            logic [STAGES-1:0] sh;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh <= '1;
                else        sh <= {sh[STAGES-2:0], raw[g]};
            end
            assign synced[g] = sh[STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= '1;
        else        prev <= synced;
    end

    assign scl_s     = synced[0];
    assign sda_s     = synced[1];
    assign scl_rise  = synced[0] & ~prev[0];
    assign scl_fall  = ~synced[0] & prev[0];
    assign start_det = synced[0] & prev[0] & prev[1] & ~synced[1];
    assign stop_det  = synced[0] & prev[0] & ~prev[1] & synced[1];

endmodule

// File: rtl/i2c_tgt_buf.sv
module i2c_tgt_buf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sw_wr,
    input  logic [W-1:0] sw_wdata,
    input  logic         sw_rd,
    input  logic         cap,
    input  logic [W-1:0] cap_data,
    input  logic         ovr_clr,
    output logic [W-1:0] data_q,
    output logic         ovr_q
);
    logic full_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            full_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (ovr_clr) ovr_q <= 1'b0;
            if (sw_rd)   full_q <= 1'b0;
            if (sw_wr) begin
                data_q <= sw_wdata;
                full_q <= 1'b0;
            end
            if (cap) begin
                if (full_q && !sw_rd) begin
                    ovr_q <= 1'b1;
                end else begin
                    data_q <= cap_data;
                    full_q <= 1'b1;
                end
            end
        end
    end

    // R8: an unread byte survives a later capture and the overrun flag rises
    p_overrun_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && full_q && !sw_rd && !sw_wr) |=> (ovr_q && $stable(data_q)));

endmodule

// File: rtl/i2c_tgt_stretch.sv
module i2c_tgt_stretch
    import i2c_tgt_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_pull,
    output logic              sda_pull,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              str_en,
    input  logic              str_at8,
    input  logic              ack_val,
    input  logic              buf_wr,
    input  logic [ADDR_W:0]   buf_wdata,
    input  logic              buf_rd,
    output logic [ADDR_W:0]   buf_rdata,
    output logic              hold_flag,
    input  logic              hold_clr,
    output logic              busy,
    output logic              ovr_flag,
    input  logic              ovr_clr
);
    localparam int BYTE_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam int IDX_W  = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    tgt_state_t        state, state_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic [BYTE_W-1:0] shreg, shreg_n;
    logic              hi, hi_n, rw, rw_n, addr_ph, addr_ph_n, hnack, hnack_n;
    logic              cap, bfall, hold8, hold9;
    logic [IDX_W-1:0]  tx_idx;

    i2c_tgt_buf #(.W(BYTE_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .sw_wr(buf_wr), .sw_wdata(buf_wdata),
        .sw_rd(buf_rd), .cap(cap), .cap_data(shreg), .ovr_clr(ovr_clr),
        .data_q(buf_rdata), .ovr_q(ovr_flag)
    );

    assign bfall = scl_fall & hi;
    assign hold8 = str_en & str_at8;
    assign hold9 = str_en & ~str_at8;

    // next-state logic
    always_comb begin
        state_n   = state;
        cnt_n     = cnt;
        shreg_n   = shreg;
        rw_n      = rw;
        addr_ph_n = addr_ph;
        hnack_n   = hnack;
        hi_n      = hi;
        cap       = 1'b0;
        if (scl_rise) hi_n = 1'b1;
        if (scl_fall) hi_n = 1'b0;
        if (start_det) begin
            state_n   = ST_ADDR;
            cnt_n     = '0;
            hi_n      = 1'b0;
            addr_ph_n = 1'b1;
        end else if (stop_det) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE, ST_SKIP: ;
                ST_ADDR, ST_RX: begin
                    if (scl_rise) shreg_n = {shreg[BYTE_W-2:0], sda_s};
                    if (bfall) begin
                        cnt_n = cnt + CNT_W'(1);
                        if (cnt == LAST_BIT) begin
                            if (state == ST_ADDR && shreg[BYTE_W-1:1] != own_addr) begin
                                state_n = ST_SKIP;
                            end else begin
                                if (state == ST_ADDR) rw_n = shreg[0];
                                else                  cap  = 1'b1;
                                state_n = hold8 ? ST_HOLD8 :
                                          (state == ST_ADDR ? ST_AACK : ST_RACK);
                            end
                        end
                    end
                end
                ST_TX: begin
                    if (bfall) begin
                        cnt_n = cnt + CNT_W'(1);
                        if (cnt == LAST_BIT) state_n = hold8 ? ST_HOLD8 : ST_HACK;
                    end
                end
                ST_AACK, ST_RACK, ST_HACK: begin
                    if (scl_rise && state == ST_HACK) hnack_n = sda_s;
                    if (bfall) begin
                        cnt_n     = '0;
                        addr_ph_n = 1'b0;
                        if (state == ST_HACK && hnack) state_n = ST_SKIP;
                        else state_n = hold9 ? ST_HOLD9 : (rw ? ST_TX : ST_RX);
                    end
                end
                ST_HOLD8: begin
                    if (hold_clr)
                        state_n = addr_ph ? ST_AACK : (rw ? ST_HACK : ST_RACK);
                end
                ST_HOLD9: begin
                    if (hold_clr) begin
                        cnt_n   = '0;
                        state_n = rw ? ST_TX : ST_RX;
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            shreg   <= '0;
            rw      <= 1'b0;
            addr_ph <= 1'b0;
            hnack   <= 1'b0;
            hi      <= 1'b0;
        end else begin
            state   <= state_n;
            cnt     <= cnt_n;
            shreg   <= shreg_n;
            rw      <= rw_n;
            addr_ph <= addr_ph_n;
            hnack   <= hnack_n;
            hi      <= hi_n;
        end
    end

    assign tx_idx = IDX_W'(LAST_BIT - cnt);

    // outputs
    always_comb begin
        scl_pull = 1'b0;
        sda_pull = 1'b0;
        busy     = 1'b0;
        unique case (state)
            ST_ADDR, ST_RX: busy = 1'b1;
            ST_HACK:        busy = 1'b1;
            ST_TX: begin
                busy     = 1'b1;
                sda_pull = ~buf_rdata[tx_idx];
            end
            ST_AACK: sda_pull = 1'b1;
            ST_RACK: sda_pull = ~ack_val;
            ST_HOLD8: begin
                scl_pull = 1'b1;
                sda_pull = addr_ph | (~rw & ~ack_val);
            end
            ST_HOLD9: begin
                scl_pull = 1'b1;
                sda_pull = rw & ~buf_rdata[BYTE_W-1];
            end
            default: ;
        endcase
    end

    assign hold_flag = scl_pull;

    // R5: a hold only starts while stretching is enabled
    p_hold_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_pull) |-> $past(str_en));

    // R6: the hold persists until software clears it
    p_hold_until_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_pull && !hold_clr) |=> scl_pull);

    // R6: a clear releases SCL on the next clock
    p_release_on_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_pull && hold_clr) |=> !scl_pull);

    // R11: no SDA change while SCL stays high
    p_sda_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_pull));

endmodule

// File: tb/i2c_tgt_stretch_tb.sv
module i2c_tgt_stretch_tb;
    localparam int H = 20;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic scl_b, sda_b;
    logic scl_pull, sda_pull, hold_flag, busy, ovr_flag;
    logic [7:0] buf_rdata;
    logic str_en = 1'b0, str_at8 = 1'b0, m_ack = 1'b0, s_nack = 1'b0, sw_nack = 1'b0;
    logic ack_val, buf_wr = 1'b0, m_rd = 1'b0, s_rd = 1'b0, buf_rd, hold_clr = 1'b0, ovr_clr = 1'b0;
    logic [7:0] buf_wdata = 8'h00;

    assign scl_b   = scl_m & ~scl_pull;
    assign sda_b   = sda_m & ~sda_pull;
    assign ack_val = m_ack | (s_nack & sw_nack);
    assign buf_rd  = m_rd | s_rd;

    i2c_tgt_stretch u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_b), .sda_i(sda_b),
        .scl_pull(scl_pull), .sda_pull(sda_pull), .own_addr(7'h29),
        .str_en(str_en), .str_at8(str_at8), .ack_val(ack_val),
        .buf_wr(buf_wr), .buf_wdata(buf_wdata), .buf_rd(buf_rd),
        .buf_rdata(buf_rdata), .hold_flag(hold_flag), .hold_clr(hold_clr),
        .busy(busy), .ovr_flag(ovr_flag), .ovr_clr(ovr_clr)
    );

    int checks = 0, errors = 0, mbit = 0, hold_seen = 0, rel_bad = 0, r11_bad = 0, r5_bad = 0;
    bit done = 0, sw_rd_en = 0, sw_tx = 0;
    int hb_q[$], bz_q[$], got_q[$], pre_q[$], post_q[$], tx_q[$];

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(output logic s);
        wt(2);
        scl_m = 1'b1;
        wt(1);
        while (!scl_b) wt(1);
        wt(H);
        s = sda_b;
        scl_m = 1'b0;
        mbit++;
        wt(H);
    endtask

    task automatic do_start();
        sda_m = 1'b1; scl_m = 1'b1; wt(H);
        sda_m = 1'b0; wt(H);
        scl_m = 1'b0; wt(H);
        mbit = 0;
    endtask

    task automatic do_stop();
        sda_m = 1'b0; wt(H);
        scl_m = 1'b1; wt(1);
        while (!scl_b) wt(1);
        wt(H);
        sda_m = 1'b1; wt(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic a);
        logic s;
        mbit = 0;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i];
            pulse(s);
        end
        sda_m = 1'b1;
        pulse(a);
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic a);
        logic s;
        mbit = 0;
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            pulse(s);
            b[i] = s;
        end
        sda_m = a;
        pulse(s);
        sda_m = 1'b1;
    endtask

    task automatic clear_q();
        hb_q.delete(); bz_q.delete(); got_q.delete(); pre_q.delete(); post_q.delete();
    endtask

    // behavioural bus-rule model, compared every clock
    logic p_scl = 1'b1, p_sp = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (scl_b && p_scl && (sda_pull != p_sp)) r11_bad++;   // R11
            if (!str_en && scl_pull) r5_bad++;                      // R5
        end
        p_scl = scl_b;
        p_sp  = sda_pull;
    end

    // software model servicing the hold
    initial begin
        forever begin
            @(negedge clk);
            if (hold_flag) begin
                hold_seen++;
                hb_q.push_back(mbit);
                bz_q.push_back(busy);
                if (sw_rd_en) begin
                    got_q.push_back(buf_rdata);
                    s_rd = 1'b1; wt(1); s_rd = 1'b0;
                end
                if (sw_nack) begin
                    s_nack = 1'b0; wt(1);
                    pre_q.push_back(sda_pull);
                    s_nack = 1'b1; wt(1);
                    post_q.push_back(sda_pull);
                end
                if (sw_tx && tx_q.size() > 0) begin
                    buf_wdata = 8'(tx_q.pop_front());
                    buf_wr = 1'b1; wt(1); buf_wr = 1'b0;
                end
                wt(20);
                if (!hold_flag || !scl_pull) rel_bad++;
                hold_clr = 1'b1; wt(1); hold_clr = 1'b0;
                if (hold_flag || scl_pull) rel_bad++;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic a;
        logic [7:0] b;
        int h0;
        wt(5);
        rst_n = 1'b1;
        wt(2);
        chk("R1 scl_pull", scl_pull, 0);
        chk("R1 sda_pull", sda_pull, 0);
        chk("R1 hold_flag", hold_flag, 0);
        chk("R1 busy", busy, 0);
        chk("R1 ovr_flag", ovr_flag, 0);

        // plain write, no stretching
        do_start();
        chk("R12 busy after START", busy, 1);
        send_byte(8'h52, a); chk("R2 address ack", a, 0);
        send_byte(8'h96, a); chk("R3 data ack", a, 0);
        do_stop();
        chk("R12 busy after STOP", busy, 0);
        chk("R3 received byte", buf_rdata, 8'h96);
        m_rd = 1'b1; wt(1); m_rd = 1'b0;

        // address mismatch with stretching enabled
        str_en = 1'b1; str_at8 = 1'b0; h0 = hold_seen;
        do_start();
        send_byte(8'h44, a); chk("R4 no address ack", a, 1);
        send_byte(8'h77, a); chk("R4 no data ack", a, 1);
        do_stop();
        chk("R4 no hold", hold_seen - h0, 0);
        chk("R4 buffer kept", buf_rdata, 8'h96);

        // write with hold after 9th fall
        clear_q(); sw_rd_en = 1; h0 = hold_seen;
        do_start();
        send_byte(8'h52, a);
        send_byte(8'h3B, a);
        send_byte(8'hE4, a);
        do_stop();
        sw_rd_en = 0;
        chk("R5 hold count", hold_seen - h0, 3);
        for (int i = 0; i < hb_q.size(); i++) chk("R5 hold at 9th fall", hb_q[i], 9);
        for (int i = 0; i < bz_q.size(); i++) chk("R9 busy low in hold", bz_q[i], 0);
        if (got_q.size() == 3) begin
            chk("R3 byte1 read in hold", got_q[1], 8'h3B);
            chk("R3 byte2 read in hold", got_q[2], 8'hE4);
        end else chk("R3 reads in hold", got_q.size(), 3);
        chk("R6 hold release", rel_bad, 0);

        // hold after 8th fall, ack changed during hold
        clear_q(); str_at8 = 1'b1; sw_nack = 1'b1;
        do_start();
        send_byte(8'h52, a); chk("R2 address ack ignores ack_val", a, 0);
        send_byte(8'h0F, a); chk("R7 late NACK seen by host", a, 1);
        do_stop();
        sw_nack = 1'b0;
        for (int i = 0; i < hb_q.size(); i++) chk("R5 hold at 8th fall", hb_q[i], 8);
        if (pre_q.size() == 2) begin
            chk("R2 address ack driven in hold", post_q[0], 1);
            chk("R7 ack driven before update", pre_q[1], 1);
            chk("R7 SDA follows new ack_val", post_q[1], 0);
        end else chk("R7 ack samples", pre_q.size(), 2);
        m_rd = 1'b1; wt(1); m_rd = 1'b0;

        // overrun without stretching
        str_en = 1'b0; m_ack = 1'b1;
        do_start();
        send_byte(8'h52, a); chk("R2 address ack with ack_val=1", a, 0);
        send_byte(8'h5A, a); chk("R3 data NACK from ack_val", a, 1);
        send_byte(8'hC3, a);
        do_stop();
        m_ack = 1'b0;
        chk("R8 overrun flag", ovr_flag, 1);
        chk("R8 first byte kept", buf_rdata, 8'h5A);
        ovr_clr = 1'b1; m_rd = 1'b1; wt(1); ovr_clr = 1'b0; m_rd = 1'b0; wt(1);
        chk("R8 overrun cleared", ovr_flag, 0);

        // read with hold after 9th fall
        clear_q(); str_en = 1'b1; str_at8 = 1'b0; sw_tx = 1; h0 = hold_seen;
        tx_q.push_back(8'hA5); tx_q.push_back(8'h3C);
        do_start();
        send_byte(8'h53, a); chk("R2 read address ack", a, 0);
        recv_byte(b, 1'b0); chk("R10 first byte", b, 8'hA5);
        recv_byte(b, 1'b1); chk("R10 second byte", b, 8'h3C);
        do_stop();
        sw_tx = 0;
        chk("R10 no hold after NACK", hold_seen - h0, 2);
        for (int i = 0; i < bz_q.size(); i++) chk("R9 busy low before transmit", bz_q[i], 0);
        chk("R12 idle after read", busy, 0);
        chk("R6 hold release", rel_bad, 0);
        chk("R11 SDA only changes with SCL low", r11_bad, 0);
        chk("R5 no hold when disabled", r5_bad, 0);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule